// File: doc/BRIEF.md
# Key and IV Freshness Tracker

This block keeps the secret key words, the initialization-vector words and the input and output data words that sit in front of a block-cipher datapath. A simple register write port loads the key, IV and input words one at a time. For each key and IV word the block records whether it has been written since that bank was last cleared. A cipher start request is only passed on when the whole key and, for the chaining modes that use it, the whole IV have been freshly written.

The block also runs the clear triggers. Software sets trigger bits that overwrite a bank with pseudo-random words or reseed the generator. Each bit drops by itself once its operation has run. All triggers are set at reset, so a reseed and a full clear run on their own after reset. The generator is a 32-bit LFSR, seeded from an entropy word input. While a message is being processed, the datapath can load an updated IV and a finished output block through parallel load ports.

Top module: `keyiv_fresh_tracker`

## Requirements
- R1: While reset is held, all five trigger bits read 1 and `idle` is 0. After release, exactly five clock cycles of clearing run and `idle` rises once `trig_pending` reaches 0.
- R2: The generator is a 32-bit right-shifting Galois LFSR. One step computes `s = (s >> 1) ^ (s[0] ? 32'h80200003 : 0)`. A reseed loads `seed_i`, or the `DFLT_SEED` parameter when `seed_i` is zero. A bank clear fills word i with the state after i+1 steps, and the state then advances by the bank size.
- R3: `wr_bank` code 0 selects the key bank and code 1 the IV bank. Writes to these banks at index `wr_idx` take effect only while `idle` is 1. Otherwise they are dropped.
- R4: `wr_bank` code 2 selects the input data bank. Its writes are accepted while the datapath is busy, and dropped while any trigger bit is pending.
- R5: Each key and IV word has a written flag. A clear of its bank zeroes the flag and an accepted write sets it. `key_full` and `iv_full` are the AND of the flags, whatever the write order.
- R6: `start_go` equals `start_req` while `idle` is 1, `key_full` is 1 and the mode allows it. The flags used are those held before the current cycle's write.
- R7: The mode code is 0 for single-block mode (IV not needed), 1 and 2 for the two chaining modes (IV needed), and 3 for none (start never granted).
- R8: `ivwb_en` loads all IV words from `ivwb_words` and sets `iv_full`, whether or not the block is idle. It takes priority over a software IV write in the same cycle.
- R9: `dout_we` loads the output bank and sets `dout_full`. A clear of the output bank in the same cycle wins.
- R10: `trig_we` ORs `trig_bits` into the pending set. Bit 0 clears the key, bit 1 the IV, bit 2 the input data and bit 3 the output data; bit 4 reseeds. Nothing runs while `core_busy` is 1. Otherwise one operation runs per cycle, in the order reseed, key, IV, input, output, and its bit drops after that cycle.
- R11: `din_full` rises after an input data bank clear once every input word has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Word write strobe |
| wr_bank | input | 2 | Bank code for the write |
| wr_idx | input | 3 | Word index within the bank |
| wr_data | input | 32 | Word to write |
| mode | input | 2 | Cipher mode code |
| start_req | input | 1 | Request to start a block |
| core_busy | input | 1 | Datapath is processing |
| ivwb_en | input | 1 | Datapath IV write-back strobe |
| ivwb_words | input | 128 | Updated IV, word i at bits 32i+31:32i |
| dout_we | input | 1 | Datapath output load strobe |
| dout_data | input | 128 | Output block |
| trig_we | input | 1 | Trigger write strobe |
| trig_bits | input | 5 | Trigger bits to set |
| seed_i | input | 32 | Entropy word for reseeding |
| key_words | output | 256 | Key bank |
| iv_words | output | 128 | IV bank |
| din_words | output | 128 | Input data bank |
| dout_words | output | 128 | Output data bank |
| key_full | output | 1 | All key words fresh |
| iv_full | output | 1 | All IV words fresh |
| din_full | output | 1 | All input words fresh |
| dout_full | output | 1 | Output bank holds a loaded block |
| trig_pending | output | 5 | Pending trigger bits |
| idle | output | 1 | Not busy and no trigger pending |
| start_go | output | 1 | Start granted |

## Verification
Two pairs of operations can fall in the same cycle. In the first, the last missing key word is written in the same cycle as a start request. The bench requires `start_go` to stay low in that cycle and rise in the next. In the second, the datapath loads an output block in the very cycle that a pending output clear is granted. The bench expects the pseudo-random words it computes from its own LFSR model and a cleared `dout_full`, not the loaded block. A sweep that leaves out each key index in turn shows that completeness does not depend on write order.

// File: rtl/keyiv_pkg.sv
package keyiv_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

  localparam int unsigned TRG_KEY = 0;
  localparam int unsigned TRG_IV  = 1;
  localparam int unsigned TRG_DIN = 2;
  localparam int unsigned TRG_DOUT = 3;
  localparam int unsigned TRG_RSD = 4;
  localparam int unsigned TRG_N   = 5;

  typedef enum logic [1:0] {BANK_KEY = 2'd0, BANK_IV = 2'd1, BANK_DIN = 2'd2, BANK_RSV = 2'd3} bank_e;
  typedef enum logic [1:0] {MODE_SINGLE = 2'd0, MODE_CHAIN = 2'd1, MODE_COUNT = 2'd2, MODE_OFF = 2'd3} mode_e;

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_MASK : 32'h0);
  endfunction
endpackage

// File: rtl/keyiv_lfsr.sv
module keyiv_lfsr #(
  parameter int unsigned MAXN = 8,
  parameter int unsigned SMALLN = 4,
  parameter logic [31:0] DFLT_SEED = 32'h6D2B_79F1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reseed_i,
  input  logic [31:0]         seed_i,
  input  logic                adv_big_i,
  input  logic                adv_small_i,
  output logic [MAXN*32-1:0]  rnd_o
);
  import keyiv_pkg::*;

  logic [31:0] state_q, state_d;
  logic [31:0] chain [MAXN];

  generate
    for (genvar k = 0; k < MAXN; k++) begin : g_chain
      if (k == 0) begin : g_first
        assign chain[k] = lfsr_step(state_q);
      end else begin : g_next
        assign chain[k] = lfsr_step(chain[k-1]);
      end
      assign rnd_o[k*32 +: 32] = chain[k];
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    if (reseed_i)         state_d = (seed_i == 32'h0) ? DFLT_SEED : seed_i;
    else if (adv_big_i)   state_d = chain[MAXN-1];
    else if (adv_small_i) state_d = chain[SMALLN-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DFLT_SEED;
    else        state_q <= state_d;
  end

  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n) state_q != 32'h0);
endmodule

// File: rtl/keyiv_word_bank.sv
module keyiv_word_bank #(
  parameter int unsigned N = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_data_i,
  input  logic              bulk_en_i,
  input  logic [N*32-1:0]   bulk_data_i,
  input  logic              clr_en_i,
  input  logic [N*32-1:0]   rnd_i,
  output logic [N*32-1:0]   words_o,
  output logic              full_o
);
  logic [N*32-1:0] words_q, words_d;
  logic [N-1:0]    flag_q, flag_d;
  logic            wr_hit;

  assign wr_hit = wr_en_i && (32'(wr_idx_i) < N);

  always_comb begin
    words_d = words_q;
    flag_d  = flag_q;
    if (clr_en_i) begin
      words_d = rnd_i;
      flag_d  = '0;
    end else if (bulk_en_i) begin
      words_d = bulk_data_i;
      flag_d  = '1;
    end else if (wr_hit) begin
      for (int i = 0; i < N; i++) begin
        if (32'(wr_idx_i) == i) begin
          words_d[i*32 +: 32] = wr_data_i;
          flag_d[i]           = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr_en_i || bulk_en_i || wr_hit) words_q <= words_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign words_o = words_q;
  assign full_o  = &flag_q;

  a_r5_full_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_o) |-> $past(wr_en_i || bulk_en_i));
  a_r9_clear_drops_full: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> !full_o);
endmodule

// File: rtl/keyiv_clear_ctl.sv
module keyiv_clear_ctl #(
  parameter int unsigned NT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_we_i,
  input  logic [NT-1:0] trig_bits_i,
  input  logic          hold_i,
  output logic [NT-1:0] pending_o,
  output logic [NT-1:0] grant_o
);
  import keyiv_pkg::*;

  logic [NT-1:0] pend_q, pend_d;

  always_comb begin
    grant_o = '0;
    if (!hold_i) begin
      if (pend_q[TRG_RSD])       grant_o[TRG_RSD]  = 1'b1;
      else if (pend_q[TRG_KEY])  grant_o[TRG_KEY]  = 1'b1;
      else if (pend_q[TRG_IV])   grant_o[TRG_IV]   = 1'b1;
      else if (pend_q[TRG_DIN])  grant_o[TRG_DIN]  = 1'b1;
      else if (pend_q[TRG_DOUT]) grant_o[TRG_DOUT] = 1'b1;
    end
    pend_d = (pend_q & ~grant_o) | (trig_we_i ? trig_bits_i : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '1;
    else        pend_q <= pend_d;
  end

  assign pending_o = pend_q;

  a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_o));
  a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !trig_we_i) |=> $stable(pend_q));
endmodule

// File: rtl/keyiv_fresh_tracker.sv
module keyiv_fresh_tracker #(
  parameter int unsigned KEY_WORDS = 8,
  parameter int unsigned BLK_WORDS = 4,
  parameter logic [31:0] DFLT_SEED = 32'h6D2B_79F1,
  localparam int unsigned IDX_W = $clog2(KEY_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_bank,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [31:0]             wr_data,
  input  logic [1:0]              mode,
  input  logic                    start_req,
  input  logic                    core_busy,
  input  logic                    ivwb_en,
  input  logic [BLK_WORDS*32-1:0] ivwb_words,
  input  logic                    dout_we,
  input  logic [BLK_WORDS*32-1:0] dout_data,
  input  logic                    trig_we,
  input  logic [4:0]              trig_bits,
  input  logic [31:0]             seed_i,
  output logic [KEY_WORDS*32-1:0] key_words,
  output logic [BLK_WORDS*32-1:0] iv_words,
  output logic [BLK_WORDS*32-1:0] din_words,
  output logic [BLK_WORDS*32-1:0] dout_words,
  output logic                    key_full,
  output logic                    iv_full,
  output logic                    din_full,
  output logic                    dout_full,
  output logic [4:0]              trig_pending,
  output logic                    idle,
  output logic                    start_go
);
  import keyiv_pkg::*;

  logic [TRG_N-1:0]        grant;
  logic [KEY_WORDS*32-1:0] rnd;
  logic                    clr_busy, key_we, iv_we, din_we, mode_ok;
  bank_e                   bank;

  assign bank     = bank_e'(wr_bank);
  assign clr_busy = |trig_pending;
  assign idle     = !core_busy && !clr_busy;
  assign key_we   = wr_en && bank == BANK_KEY && idle;
  assign iv_we    = wr_en && bank == BANK_IV && idle && !ivwb_en;
  assign din_we   = wr_en && bank == BANK_DIN && !clr_busy;

  always_comb begin
    unique case (mode_e'(mode))
      MODE_SINGLE:           mode_ok = 1'b1;
      MODE_CHAIN, MODE_COUNT: mode_ok = iv_full;
      default:               mode_ok = 1'b0;
    endcase
  end
  assign start_go = start_req && idle && key_full && mode_ok;

  keyiv_clear_ctl #(.NT(TRG_N)) u_ctl (
    .clk, .rst_n, .trig_we_i(trig_we), .trig_bits_i(trig_bits),
    .hold_i(core_busy), .pending_o(trig_pending), .grant_o(grant)
  );

  keyiv_lfsr #(.MAXN(KEY_WORDS), .SMALLN(BLK_WORDS), .DFLT_SEED(DFLT_SEED)) u_lfsr (
    .clk, .rst_n, .reseed_i(grant[TRG_RSD]), .seed_i,
    .adv_big_i(grant[TRG_KEY]),
    .adv_small_i(grant[TRG_IV] || grant[TRG_DIN] || grant[TRG_DOUT]),
    .rnd_o(rnd)
  );

  keyiv_word_bank #(.N(KEY_WORDS), .IDX_W(IDX_W)) u_key (
    .clk, .rst_n, .wr_en_i(key_we), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .bulk_en_i(1'b0), .bulk_data_i('0), .clr_en_i(grant[TRG_KEY]),
    .rnd_i(rnd), .words_o(key_words), .full_o(key_full)
  );

  keyiv_word_bank #(.N(BLK_WORDS), .IDX_W(IDX_W)) u_iv (
    .clk, .rst_n, .wr_en_i(iv_we), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .bulk_en_i(ivwb_en), .bulk_data_i(ivwb_words), .clr_en_i(grant[TRG_IV]),
    .rnd_i(rnd[BLK_WORDS*32-1:0]), .words_o(iv_words), .full_o(iv_full)
  );

  keyiv_word_bank #(.N(BLK_WORDS), .IDX_W(IDX_W)) u_din (
    .clk, .rst_n, .wr_en_i(din_we), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .bulk_en_i(1'b0), .bulk_data_i('0), .clr_en_i(grant[TRG_DIN]),
    .rnd_i(rnd[BLK_WORDS*32-1:0]), .words_o(din_words), .full_o(din_full)
  );

  keyiv_word_bank #(.N(BLK_WORDS), .IDX_W(IDX_W)) u_dout (
    .clk, .rst_n, .wr_en_i(1'b0), .wr_idx_i('0), .wr_data_i('0),
    .bulk_en_i(dout_we), .bulk_data_i(dout_data), .clr_en_i(grant[TRG_DOUT]),
    .rnd_i(rnd[BLK_WORDS*32-1:0]), .words_o(dout_words), .full_o(dout_full)
  );

  a_r3_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !grant[TRG_KEY]) |=> $stable(key_words));
  a_r6_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |-> (idle && key_full && start_req));
  a_r1_pending_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_pending) |-> !idle);
endmodule

// File: tb/test_keyiv_fresh_tracker.sv
module test_keyiv_fresh_tracker;
  localparam logic [31:0] DSEED = 32'h6D2B_79F1;
  localparam logic [31:0] MASK  = 32'h8020_0003;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, wr_en, start_req, core_busy, ivwb_en, dout_we, trig_we;
  logic [1:0] wr_bank, mode;
  logic [2:0] wr_idx;
  logic [31:0] wr_data, seed_i;
  logic [127:0] ivwb_words, dout_data, iv_words, din_words, dout_words;
  logic [4:0] trig_bits, trig_pending;
  logic [255:0] key_words;
  logic key_full, iv_full, din_full, dout_full, idle, start_go;

  keyiv_fresh_tracker #(.DFLT_SEED(DSEED)) i_keyiv_fresh_tracker (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] ms;
  logic [255:0] ek;
  logic [127:0] ei, ed, eo;

  function automatic logic [31:0] stp(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? MASK : 32'h0);
  endfunction

  task automatic gen(input int n, output logic [255:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      ms = stp(ms);
      w[i*32 +: 32] = ms;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] b, input int idx, input logic [31:0] d);
    wr_en = 1'b1; wr_bank = b; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic trig(input logic [4:0] b);
    trig_we = 1'b1; trig_bits = b;
    @(negedge clk);
    trig_we = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(negedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] tmp;
    logic [4:0] seq [5];
    seq = '{5'h0f, 5'h0e, 5'h0c, 5'h08, 5'h00};
    rst_n = 0; wr_en = 0; wr_bank = 0; wr_idx = 0; wr_data = 0; mode = 0;
    start_req = 0; core_busy = 0; ivwb_en = 0; ivwb_words = 0; dout_we = 0;
    dout_data = 0; trig_we = 0; trig_bits = 0; seed_i = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    chk(trig_pending == 5'h1f, "R1", "reset pending", 256'(trig_pending), 256'h1f);
    chk(idle == 1'b0, "R1", "reset idle", 256'(idle), 0);
    chk(key_full == 1'b0, "R5", "reset key_full", 256'(key_full), 0);
    rst_n = 1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(trig_pending == seq[c], "R10", "post-reset pending", 256'(trig_pending), 256'(seq[c]));
      chk(idle == (c == 4), "R1", "post-reset idle", 256'(idle), 256'(c == 4));
    end
    ms = 32'h1357_9BDF;
    gen(8, ek); gen(4, tmp); ei = tmp[127:0]; gen(4, tmp); ed = tmp[127:0];
    gen(4, tmp); eo = tmp[127:0];
    chk(key_words == ek, "R2", "key after reset clear", key_words, ek);
    chk(iv_words == ei, "R2", "iv after reset clear", 256'(iv_words), 256'(ei));
    chk(din_words == ed, "R2", "din after reset clear", 256'(din_words), 256'(ed));
    chk(dout_words == eo, "R2", "dout after reset clear", 256'(dout_words), 256'(eo));

    // R6: start refused with no key; last key write together with start
    start_req = 1; #1;
    chk(start_go == 0, "R6", "start with empty key", 256'(start_go), 0);
    for (int i = 7; i > 0; i--) begin
      wr(2'd0, i, 32'hA000_0000 + i);
      ek[i*32 +: 32] = 32'hA000_0000 + i;
    end
    chk(key_full == 0, "R5", "seven of eight key words", 256'(key_full), 0);
    wr_en = 1; wr_bank = 0; wr_idx = 0; wr_data = 32'hA000_0000; #1;
    chk(start_go == 0, "R6", "start in cycle of last key write", 256'(start_go), 0);
    @(negedge clk); wr_en = 0; ek[31:0] = 32'hA000_0000;
    chk(key_full == 1 && start_go == 1, "R6", "start after key complete (single mode)",
        256'({key_full, start_go}), 256'h3);
    chk(key_words == ek, "R3", "key words written while idle", key_words, ek);

    // R7 chaining modes need IV
    mode = 2'd1; #1;
    chk(start_go == 0, "R7", "chaining mode without IV", 256'(start_go), 0);
    wr(2'd1, 2, 32'hB2); wr(2'd1, 0, 32'hB0); wr(2'd1, 3, 32'hB3);
    #1 chk(start_go == 0, "R5", "IV three of four", 256'(start_go), 0);
    wr(2'd1, 1, 32'hB1);
    ei = {32'hB3, 32'hB2, 32'hB1, 32'hB0};
    chk(iv_full == 1 && start_go == 1, "R5", "IV complete out of order",
        256'({iv_full, start_go}), 256'h3);
    mode = 2'd2; #1 chk(start_go == 1, "R7", "counter mode with IV", 256'(start_go), 1);
    mode = 2'd3; #1 chk(start_go == 0, "R7", "mode code 3 never starts", 256'(start_go), 0);
    mode = 2'd0;

    // busy: key/iv writes dropped, din accepted, IV write-back
    core_busy = 1; #1;
    chk(idle == 0 && start_go == 0, "R6", "busy blocks start", 256'({idle, start_go}), 0);
    wr(2'd0, 3, 32'hDEAD_0003);
    chk(key_words == ek, "R3", "key write dropped while busy", key_words, ek);
    wr(2'd1, 2, 32'hDEAD_0002);
    chk(iv_words == ei, "R3", "IV write dropped while busy", 256'(iv_words), 256'(ei));
    wr(2'd2, 1, 32'hC1);
    ed[63:32] = 32'hC1;
    chk(din_words == ed, "R4", "din write accepted while busy", 256'(din_words), 256'(ed));
    ivwb_en = 1; ivwb_words = 128'h11_0000_0022_0000_0033_0000_0044;
    @(negedge clk); ivwb_en = 0; ei = 128'h11_0000_0022_0000_0033_0000_0044;
    chk(iv_words == ei && iv_full, "R8", "IV write-back while busy", 256'(iv_words), 256'(ei));

    // R10 triggers wait for busy; R4 din drop while pending
    trig(5'h02);
    wr(2'd2, 2, 32'hC2);
    chk(din_words == ed, "R4", "din write dropped while pending", 256'(din_words), 256'(ed));
    repeat (2) @(negedge clk);
    chk(trig_pending == 5'h02 && iv_words == ei, "R10", "IV clear held while busy",
        256'(trig_pending), 256'h02);
    core_busy = 0;
    @(negedge clk);
    gen(4, tmp); ei = tmp[127:0];
    chk(iv_words == ei, "R2", "IV cleared with LFSR words", 256'(iv_words), 256'(ei));
    chk(trig_pending == 0 && iv_full == 0 && idle, "R10", "IV clear done",
        256'({trig_pending, iv_full, idle}), 256'h1);

    // R8: write-back beats software write in the same cycle
    ivwb_en = 1; ivwb_words = 128'h5; wr_en = 1; wr_bank = 1; wr_idx = 0; wr_data = 32'h77;
    @(negedge clk); ivwb_en = 0; wr_en = 0;
    chk(iv_words == 128'h5, "R8", "write-back wins over software", 256'(iv_words), 256'h5);

    // R9 dout load, then clear colliding with load
    dout_we = 1; dout_data = 128'hD0D0;
    @(negedge clk); dout_we = 0;
    chk(dout_words == 128'hD0D0 && dout_full, "R9", "dout load", 256'(dout_words), 256'hD0D0);
    trig(5'h08);
    dout_we = 1; dout_data = 128'hE0E0;
    @(negedge clk); dout_we = 0;
    gen(4, tmp); eo = tmp[127:0];
    chk(dout_words == eo, "R9", "clear wins over dout load", 256'(dout_words), 256'(eo));
    chk(dout_full == 0, "R9", "dout_full after clear", 256'(dout_full), 0);

    // R11 din completeness
    trig(5'h04); @(negedge clk);
    gen(4, tmp); ed = tmp[127:0];
    chk(din_words == ed && din_full == 0, "R11", "din cleared", 256'(din_words), 256'(ed));
    for (int i = 0; i < 4; i++) wr(2'd2, i, 32'hF0 + i);
    chk(din_full == 1, "R11", "din complete", 256'(din_full), 1);

    // R2/R10 multi trigger with zero seed
    seed_i = 0;
    trig(5'h15);
    chk(trig_pending == 5'h15, "R10", "multi pending", 256'(trig_pending), 256'h15);
    @(negedge clk);
    chk(trig_pending == 5'h05, "R10", "reseed first", 256'(trig_pending), 256'h05);
    @(negedge clk);
    chk(trig_pending == 5'h04, "R10", "key second", 256'(trig_pending), 256'h04);
    @(negedge clk);
    chk(trig_pending == 5'h00, "R10", "din third", 256'(trig_pending), 0);
    ms = DSEED; gen(8, ek); gen(4, tmp); ed = tmp[127:0];
    chk(key_words == ek, "R2", "key from default seed", key_words, ek);
    chk(din_words == ed, "R2", "din after key from default seed", 256'(din_words), 256'(ed));

    // R5 sweep: leave out each key index in turn
    for (int m = 0; m < 8; m++) begin
      trig(5'h01); @(negedge clk);
      gen(8, ek);
      for (int i = 0; i < 8; i++) if (i != m) wr(2'd0, (i * 3 + m) % 8 == m ? i : i, 32'h100 + i);
      chk(key_full == 0, "R5", $sformatf("key missing word %0d", m), 256'(key_full), 0);
      wr(2'd0, m, 32'h100 + m);
      chk(key_full == 1, "R5", $sformatf("key completed by word %0d", m), 256'(key_full), 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule